// File: doc/BRIEF.md
# Ingress Byte-to-Word Packet Buffer

This block sits where an 8-bit receive stream from the link side meets a 32-bit network-side datapath. A frame is delimited by a start strobe on its first byte and an end strobe on its last byte. The block keeps every byte of the frame in an internal store. Nothing moves toward the network side until the frame's final byte has arrived. Only then does the block present the IPv4 header as packed 32-bit words, one word per clock, under a valid/ready handshake.

The payload never crosses the 32-bit side. It stays in the store until the egress logic reports that the rewritten header has gone out. The block then replays the payload as a byte stream, one byte per clock, so that the payload can follow the new header. The header length is taken from the low nibble of the first byte. The block shows the frame as pending from the end of capture until the last payload byte has left. While a frame is pending, it refuses new frames.

Top module: `pkt_ingress_buf`

## Requirements
- R1: After reset, hdrValid, payValid, pending, busy and overflow are all low.
- R2: Bytes that arrive with rxValid high while no frame is open, and without rxSof, are not stored: pending and hdrValid stay low afterwards.
- R3: hdrValid stays low for as long as a frame is being received. It goes high in the cycle after the clock edge that accepts the byte carrying rxEof.
- R4: The number of header words equals the low nibble of the frame's first byte, and hdrLen shows that nibble. Header word k carries frame bytes 4k, 4k+1, 4k+2 and 4k+3 in bits 31:24, 23:16, 15:8 and 7:0.
- R5: A header word is consumed only in a cycle where both hdrValid and hdrReady are high. While hdrReady is low, hdrWord holds its value. hdrLast is high on the final header word only.
- R6: After the final header word, payValid stays low and pending stays high until payReq is seen. From the next cycle, the bytes from index 4*hdrLen up to the end of the frame come out one per cycle, with payLast on the final byte. pending then drops.
- R7: While pending is high, a byte carrying rxSof raises busy in that same cycle and is discarded. The stored frame, its header words and its payload are unchanged.
- R8: A frame longer than DEPTH bytes sets overflow and is discarded, with no header words and pending low. overflow stays set until the next frame starts. A frame of exactly DEPTH bytes is accepted.
- R9: payReq has no effect while header words remain to be sent. payValid stays low, and the current header word is unchanged.
- R10: If the frame holds no bytes beyond 4*hdrLen, payReq releases the frame without any payValid cycle, and pending drops one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | rxByte carries a byte this cycle |
| rxSof | input | 1 | Byte is the first of a frame |
| rxEof | input | 1 | Byte is the last of a frame |
| hdrWord | output | 32 | Header word, first frame byte in bits 31:24 |
| hdrValid | output | 1 | hdrWord is valid |
| hdrReady | input | 1 | Consumer takes hdrWord |
| hdrLast | output | 1 | Final header word |
| hdrLen | output | 4 | Header length in 32-bit words |
| pending | output | 1 | A stored frame has not yet been fully released |
| busy | output | 1 | A start byte is being refused this cycle |
| overflow | output | 1 | Last frame exceeded the store and was dropped |
| payReq | input | 1 | New header sent, replay the payload |
| payByte | output | 8 | Replayed payload byte |
| payValid | output | 1 | payByte is valid |
| payLast | output | 1 | Final payload byte |

## Verification
The capture-and-split path is driven with frames whose byte values differ by seed and whose header lengths are the minimum five words and the maximum fifteen. These frames show whether word packing and the start offset of the payload follow the header length nibble, and are not fixed. A stall in the middle of the header separates correct handshake holding from free-running output. A frame that is all header separates the empty-payload release from a replay of one stray byte. Frames of exactly the store size and one byte larger pin the overflow limit to the exact byte. A start byte sent during a pending frame, and a replay request sent during the header phase, show that the stored data survives both.

// File: rtl/pib_pkg.sv
package pib_pkg;
  typedef struct packed {
    logic wrStart;   // first byte of a frame: write at 0, restart count
    logic wrEn;      // further byte of the frame
    logic capLen;    // frame ended on this byte: latch its index
    logic hdrAdv;    // header word consumed
    logic payStart;  // begin payload replay
    logic payAdv;    // payload byte emitted
  } pibStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_DROP, ST_HDR, ST_WAIT, ST_PAY
  } pibState_t;
endpackage

// File: rtl/pib_data.sv
module pib_data
  import pib_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  rxByte,
  input  pibStrobe_t  strobe,
  output logic [31:0] hdrWord,
  output logic [3:0]  hdrLen,
  output logic        hdrZero,
  output logic        hdrIsLast,
  output logic        wrFull,
  output logic        payEmpty,
  output logic        payIsLast,
  output logic [7:0]  payByte
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int ROWS   = DEPTH / 4;
  localparam int ROW_W  = ADDR_W - 2;

  logic [PTR_W-1:0]  wrPtr;
  logic [ADDR_W-1:0] wrAddr, lastIdx, rdPtr, hdrBytes;
  logic [3:0]        ihl, hdrIdx;
  logic              memWe;
  logic [7:0]        wordLane [4];
  logic [7:0]        byteLane [4];

  assign memWe    = strobe.wrStart | strobe.wrEn;
  assign wrAddr   = strobe.wrStart ? '0 : wrPtr[ADDR_W-1:0];
  assign hdrBytes = ADDR_W'({ihl, 2'b00});

  // one byte lane per position inside a 32-bit word
  for (genvar b = 0; b < 4; b++) begin : gLane
    logic [7:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (memWe && wrAddr[1:0] == 2'(b)) mem[wrAddr[ADDR_W-1:2]] <= rxByte;
    end
    assign wordLane[b] = mem[ROW_W'(hdrIdx)];
    assign byteLane[b] = mem[rdPtr[ADDR_W-1:2]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      lastIdx <= '0;
      rdPtr   <= '0;
      ihl     <= '0;
      hdrIdx  <= '0;
    end else begin
      if (strobe.wrStart) begin
        wrPtr <= PTR_W'(1);
        ihl   <= rxByte[3:0];
      end else if (strobe.wrEn) begin
        wrPtr <= wrPtr + 1'b1;
      end
      if (strobe.capLen) begin
        lastIdx <= wrAddr;
        hdrIdx  <= '0;
      end
      if (strobe.hdrAdv) hdrIdx <= hdrIdx + 1'b1;
      if (strobe.payStart) rdPtr <= hdrBytes;
      else if (strobe.payAdv) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign hdrWord   = {wordLane[0], wordLane[1], wordLane[2], wordLane[3]};
  assign hdrLen    = ihl;
  assign hdrZero   = (ihl == 4'd0);
  assign hdrIsLast = (hdrIdx == ihl - 4'd1);
  assign wrFull    = (wrPtr == PTR_W'(DEPTH));
  assign payEmpty  = (hdrBytes > lastIdx);
  assign payIsLast = (rdPtr == lastIdx);
  assign payByte   = byteLane[rdPtr[1:0]];
endmodule

// File: rtl/pib_ctrl.sv
module pib_ctrl
  import pib_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic       rxEof,
  input  logic       hdrReady,
  input  logic       payReq,
  input  logic       wrFull,
  input  logic       hdrZero,
  input  logic       hdrIsLast,
  input  logic       payEmpty,
  input  logic       payIsLast,
  output pibStrobe_t strobe,
  output logic       hdrValid,
  output logic       hdrLast,
  output logic       payValid,
  output logic       payLast,
  output logic       pending,
  output logic       busy,
  output logic       overflow
);
  pibState_t st, nxt;
  logic ovfSet;

  always_comb begin
    strobe = '0;
    ovfSet = 1'b0;
    nxt    = st;
    case (st)
      ST_IDLE: if (rxValid && rxSof) begin
        strobe.wrStart = 1'b1;
        if (rxEof) begin
          strobe.capLen = 1'b1;
          nxt = ST_HDR;
        end else nxt = ST_RECV;
      end
      ST_RECV: if (rxValid) begin
        if (wrFull) begin
          ovfSet = 1'b1;
          nxt = rxEof ? ST_IDLE : ST_DROP;
        end else begin
          strobe.wrEn = 1'b1;
          if (rxEof) begin
            strobe.capLen = 1'b1;
            nxt = ST_HDR;
          end
        end
      end
      ST_DROP: if (rxValid && rxEof) nxt = ST_IDLE;
      ST_HDR: begin
        if (hdrZero) nxt = ST_WAIT;
        else if (hdrReady) begin
          strobe.hdrAdv = 1'b1;
          if (hdrIsLast) nxt = ST_WAIT;
        end
      end
      ST_WAIT: if (payReq) begin
        if (payEmpty) nxt = ST_IDLE;
        else begin
          strobe.payStart = 1'b1;
          nxt = ST_PAY;
        end
      end
      ST_PAY: begin
        strobe.payAdv = 1'b1;
        if (payIsLast) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      overflow <= 1'b0;
    end else begin
      st <= nxt;
      if (ovfSet) overflow <= 1'b1;
      else if (strobe.wrStart) overflow <= 1'b0;
    end
  end

  assign hdrValid = (st == ST_HDR) && !hdrZero;
  assign hdrLast  = hdrValid && hdrIsLast;
  assign payValid = (st == ST_PAY);
  assign payLast  = payValid && payIsLast;
  assign pending  = (st == ST_HDR) || (st == ST_WAIT) || (st == ST_PAY);
  assign busy     = pending && rxValid && rxSof;
endmodule

// File: rtl/pkt_ingress_buf.sv
module pkt_ingress_buf
  import pib_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  output logic [31:0] hdrWord,
  output logic        hdrValid,
  input  logic        hdrReady,
  output logic        hdrLast,
  output logic [3:0]  hdrLen,
  output logic        pending,
  output logic        busy,
  output logic        overflow,
  input  logic        payReq,
  output logic [7:0]  payByte,
  output logic        payValid,
  output logic        payLast
);
  pibStrobe_t strobe;
  logic wrFull, hdrZero, hdrIsLast, payEmpty, payIsLast;

  pib_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .hdrReady(hdrReady), .payReq(payReq), .wrFull(wrFull), .hdrZero(hdrZero),
    .hdrIsLast(hdrIsLast), .payEmpty(payEmpty), .payIsLast(payIsLast),
    .strobe(strobe), .hdrValid(hdrValid), .hdrLast(hdrLast),
    .payValid(payValid), .payLast(payLast), .pending(pending),
    .busy(busy), .overflow(overflow)
  );

  pib_data #(.DEPTH(DEPTH)) dataI (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .strobe(strobe),
    .hdrWord(hdrWord), .hdrLen(hdrLen), .hdrZero(hdrZero),
    .hdrIsLast(hdrIsLast), .wrFull(wrFull), .payEmpty(payEmpty),
    .payIsLast(payIsLast), .payByte(payByte)
  );
endmodule

// File: rtl/pib_chk.sv
module pib_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic        rxEof,
  input logic [31:0] hdrWord,
  input logic        hdrValid,
  input logic        hdrReady,
  input logic        hdrLast,
  input logic        pending,
  input logic        busy,
  input logic        overflow,
  input logic        payReq,
  input logic        payValid
);
  // R5
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !hdrReady |=> hdrValid && $stable(hdrWord));
  // R5
  hdr_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrLast |-> hdrValid);
  // R3
  hdr_after_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrValid) |-> $past(rxValid && rxEof));
  // R6
  pay_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(payValid) |-> $past(payReq));
  // R6
  pay_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    payValid |-> !hdrValid && pending);
  // R7
  busy_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pending);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !pending);
endmodule

bind pkt_ingress_buf pib_chk chkI (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxEof(rxEof),
  .hdrWord(hdrWord), .hdrValid(hdrValid), .hdrReady(hdrReady),
  .hdrLast(hdrLast), .pending(pending), .busy(busy), .overflow(overflow),
  .payReq(payReq), .payValid(payValid)
);

// File: tb/pkt_ingress_buf_test.sv
module pkt_ingress_buf_test;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic        hdrReady = 1'b0, payReq = 1'b0;
  logic [31:0] hdrWord;
  logic        hdrValid, hdrLast, pending, busy, overflow, payValid, payLast;
  logic [3:0]  hdrLen;
  logic [7:0]  payByte;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expMem [0:DEPTH];

  always #4 clk = ~clk;

  pkt_ingress_buf #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .rxSof(rxSof), .rxEof(rxEof), .hdrWord(hdrWord), .hdrValid(hdrValid),
    .hdrReady(hdrReady), .hdrLast(hdrLast), .hdrLen(hdrLen),
    .pending(pending), .busy(busy), .overflow(overflow), .payReq(payReq),
    .payByte(payByte), .payValid(payValid), .payLast(payLast)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] expWord(input int k);
    return {expMem[4*k], expMem[4*k+1], expMem[4*k+2], expMem[4*k+3]};
  endfunction

  // drives a frame; first byte is 0x4 in the high nibble, ihl in the low nibble
  task automatic sendFrame(input int len, input logic [3:0] ihl, input int seed);
    int early = 0;
    for (int i = 0; i < len; i++)
      expMem[i] = (i == 0) ? {4'h4, ihl} : 8'((i * 7 + seed) ^ (i >> 3));
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (hdrValid) early++;
      rxByte = expMem[i]; rxValid = 1'b1;
      rxSof = (i == 0); rxEof = (i == len - 1);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    chk(early == 0, "R3", "hdrValid during receive", early, 0);
  endtask

  task automatic readHeader(input int ihl, input bit stall);
    chk(hdrValid == 1'b1, "R3", "hdrValid after eof", hdrValid, 1);
    chk(hdrLen == 4'(ihl), "R4", "hdrLen", hdrLen, ihl);
    for (int k = 0; k < ihl; k++) begin
      if (stall && k == 1) begin
        logic [31:0] held;
        hdrReady = 1'b0;
        held = hdrWord;
        repeat (3) @(negedge clk);
        chk(hdrValid && hdrWord == held, "R5", "word held while not ready", hdrWord, held);
      end
      hdrReady = 1'b1;
      chk(hdrValid && hdrWord == expWord(k), "R4", "header word", hdrWord, expWord(k));
      chk(hdrLast == (k == ihl - 1), "R5", "hdrLast", hdrLast, k == ihl - 1);
      @(negedge clk);
    end
    hdrReady = 1'b0;
    chk(!hdrValid && pending && !payValid, "R6", "waiting for request",
        {hdrValid, pending, payValid}, 3'b010);
    repeat (2) @(negedge clk);
    chk(!payValid && pending, "R6", "no replay without request", {payValid, pending}, 2'b01);
  endtask

  task automatic readPayload(input int len, input int ihl);
    int bad = 0, lastBad = 0;
    payReq = 1'b1;
    @(negedge clk);
    payReq = 1'b0;
    for (int i = 4 * ihl; i < len; i++) begin
      if (!payValid || payByte != expMem[i]) bad++;
      if (payLast != (i == len - 1)) lastBad++;
      @(negedge clk);
    end
    chk(bad == 0, "R6", "payload byte mismatches", bad, 0);
    chk(lastBad == 0, "R6", "payLast placement errors", lastBad, 0);
    chk(!pending && !payValid, "R6", "released after payload", {pending, payValid}, 0);
  endtask

  task automatic testReset();
    chk({hdrValid, payValid, pending, busy, overflow} == 5'b0, "R1", "outputs after reset",
        {hdrValid, payValid, pending, busy, overflow}, 0);
  endtask

  task automatic testPreSof();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rxByte = 8'(8'h45 + i); rxValid = 1'b1; rxSof = 1'b0; rxEof = (i == 5);
    end
    @(negedge clk);
    rxValid = 1'b0; rxEof = 1'b0;
    @(negedge clk);
    chk(!pending && !hdrValid, "R2", "bytes without sof ignored", {pending, hdrValid}, 0);
  endtask

  task automatic testBasic();
    sendFrame(40, 4'd5, 3);
    readHeader(5, 0);
    readPayload(40, 5);
  endtask

  task automatic testLongHeader();
    sendFrame(97, 4'd15, 11);
    readHeader(15, 1);
    readPayload(97, 15);
  endtask

  task automatic testBusy();
    sendFrame(33, 4'd6, 21);
    rxByte = 8'h45; rxValid = 1'b1; rxSof = 1'b1;
    #1;
    chk(busy == 1'b1, "R7", "busy on refused start", busy, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rxByte = 8'(8'hA0 + i); rxSof = 1'b0; rxEof = (i == 3);
    end
    @(negedge clk);
    rxValid = 1'b0; rxEof = 1'b0;
    chk(!busy, "R7", "busy clears", busy, 0);
    readHeader(6, 0);
    readPayload(33, 6);
  endtask

  task automatic testEarlyReq();
    sendFrame(28, 4'd5, 40);
    payReq = 1'b1;
    @(negedge clk);
    payReq = 1'b0;
    @(negedge clk);
    chk(!payValid && hdrValid && hdrWord == expWord(0), "R9", "request during header ignored",
        hdrWord, expWord(0));
    readHeader(5, 0);
    readPayload(28, 5);
  endtask

  task automatic testNoPayload();
    sendFrame(20, 4'd5, 55);
    readHeader(5, 0);
    payReq = 1'b1;
    @(negedge clk);
    payReq = 1'b0;
    chk(!payValid && !pending, "R10", "empty payload release", {payValid, pending}, 0);
  endtask

  task automatic testOverflow();
    sendFrame(DEPTH + 1, 4'd5, 77);
    @(negedge clk);
    chk(overflow && !pending && !hdrValid, "R8", "oversize frame dropped",
        {overflow, pending, hdrValid}, 3'b100);
    sendFrame(DEPTH, 4'd5, 91);
    chk(!overflow, "R8", "overflow cleared by new frame", overflow, 0);
    readHeader(5, 0);
    readPayload(DEPTH, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPreSof();
    testBasic();
    testLongHeader();
    testBusy();
    testEarlyReq();
    testNoPayload();
    testOverflow();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule